// File: doc/BRIEF.md
# Timeslot Interchange with Per-Channel Delay Mode

This block moves 8-bit channel samples between two serial streams that share one bit clock. One bit travels per clock. A frame pulse marks the first bit of channel 0. Each incoming sample is written into a data memory with three banks, so the memory always holds the frame now arriving and the two frames before it. A connection memory has one word per output channel. That word names the source channel and selects the throughput-delay mode for the output channel.

In constant mode every output channel of a frame is drawn from the same input frame, two frames back. The grouping of an input frame therefore survives the switch. In variable mode the sample leaves as soon as it can. The block uses the newest input frame whose copy of the source channel is complete at least seven slots before the destination slot, so the delay runs from 7 channels up to one frame plus 6 channels. Variable mode needs a global enable in the control register. A channel that asks for variable mode while that enable is clear sends an all-ones byte.

Top module: `tsi_chan_switch`

## Requirements
- R1: While reset is held, and in the first clocks after it is released, `ser_o` is 0 and the variable-delay enable is clear.
- R2: The clock in which `fp_i` is high is in-frame position 0. Position p carries bit 7-(p mod 8) of channel p/8, so samples go MSB first. The input and the output use the same position count.
- R3: A channel in constant mode (connection word bit 14 = 0) sends, in output frame N, the byte its source channel received in input frame N-2.
- R4: A channel d in variable mode with source s where d >= s+7 sends the byte of input frame N.
- R5: A channel d in variable mode where d < s+7 <= d+NUM_CH sends the byte of input frame N-1.
- R6: A channel d in variable mode where s+7 > d+NUM_CH sends the byte of input frame N-2.
- R7: A channel in variable mode sends 0xFF while the variable enable (control word bit 4) is clear. Constant channels are unaffected.
- R8: A connection word is written at address d with `cm_we`. Bit 14 selects the mode and bits [CH_W-1:0] give the source channel. A control word is written with `ctl_we`, and bit 4 is the variable enable. All other bits of both words have no effect.
- R9: Constant and variable channels can be mixed in one frame. Each follows its own rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Frame pulse, high for the first bit of a frame |
| ser_i | input | 1 | Serial input stream |
| ser_o | output | 1 | Serial output stream (registered) |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | CH_W | Output channel whose word is written |
| cm_wdata | input | 16 | Connection word: bit 14 mode, low bits source |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control word: bit 4 variable enable |

## Verification
The byte for output channel d is due in positions d*8 to d*8+7 of the output frame. That frame is counted from the same frame pulse as the input frame. The source frame is N, N-1 or N-2, depending on the mode and the slot distance. The driver pushes the expected bytes for a frame into the queue at position 0. The monitor samples `ser_o` two nanoseconds after each falling edge and completes a byte at every position ending in 7. Frames in which the control word or connection words are rewritten are pushed unchecked. Checking resumes only with the next full frame, because channel 0 of a frame is fetched during the last channel of the previous one.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SAMPLE_W      = 8;
  localparam int BIT_W         = $clog2(SAMPLE_W);
  localparam int NUM_BANKS     = 3;
  localparam int CM_VAR_BIT    = 14;
  localparam int CTL_VAREN_BIT = 4;

  typedef logic [1:0] bank_t;

  // (b + k) modulo the bank count
  function automatic bank_t bank_add(bank_t b, int unsigned k);
    int unsigned t;
    t = (32'(b) + k) % NUM_BANKS;
    return t[1:0];
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int FRAME_BITS = NUM_CH * SAMPLE_W,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fp_i,
  output logic [POS_W-1:0] pos_eff,
  output logic [POS_W-1:0] pos_q,
  output bank_t            bank_eff,
  output bank_t            bank_q
);
  always_comb begin
    pos_eff  = fp_i ? '0 : pos_q;
    bank_eff = fp_i ? bank_add(bank_q, 1) : bank_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      bank_q <= '0;
    end else begin
      pos_q  <= (pos_eff == POS_W'(FRAME_BITS - 1)) ? '0 : pos_eff + 1'b1;
      bank_q <= bank_eff;
    end
  end
endmodule

// File: rtl/tsi_sdp_ram.sv
module tsi_sdp_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 96,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsi_out_path.sv
module tsi_out_path
  import tsi_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int VAR_GAP = 7,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int POS_W = $clog2(NUM_CH * SAMPLE_W),
  localparam int DAW   = $clog2(NUM_BANKS * NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [POS_W-1:0]    pos_eff,
  input  bank_t               bank_eff,
  input  logic                var_en,
  input  logic [CH_W:0]       cm_rdata,
  input  logic [SAMPLE_W-1:0] dm_rdata,
  output logic                cm_re,
  output logic [CH_W-1:0]     cm_raddr,
  output logic                dm_re,
  output logic [DAW-1:0]      dm_raddr,
  output logic                rd_stb,
  output logic                load_stb,
  output logic                fill_q,
  output logic [SAMPLE_W-1:0] sh_q,
  output logic                ser_o
);
  logic [BIT_W-1:0] bit_idx;
  logic [CH_W-1:0]  ch_idx, dst_q, src;
  logic             last_ch, var_mode;
  bank_t            tgt_q, rd_bank;

  // Bank that holds the wanted input frame, relative to the target output frame
  function automatic bank_t pick_bank(bank_t tgt, logic [CH_W-1:0] d,
                                      logic [CH_W-1:0] s, logic vm);
    int unsigned di, si;
    di = 32'(d);
    si = 32'(s);
    if (!vm) return bank_add(tgt, 1);                       // frame N-2
    if (di >= si + VAR_GAP) return tgt;                     // frame N
    if (di + NUM_CH >= si + VAR_GAP) return bank_add(tgt, 2); // frame N-1
    return bank_add(tgt, 1);                                // frame N-2
  endfunction

  assign bit_idx  = pos_eff[BIT_W-1:0];
  assign ch_idx   = pos_eff[POS_W-1:BIT_W];
  assign last_ch  = (ch_idx == CH_W'(NUM_CH - 1));

  // Stage A: look up the connection word of the next output channel
  assign cm_re    = (bit_idx == BIT_W'(4));
  assign cm_raddr = last_ch ? '0 : ch_idx + 1'b1;

  // Stage B: fetch the sample from the chosen bank
  assign rd_stb   = (bit_idx == BIT_W'(5));
  assign src      = cm_rdata[CH_W-1:0];
  assign var_mode = cm_rdata[CH_W];
  assign rd_bank  = pick_bank(tgt_q, dst_q, src, var_mode);
  assign dm_re    = rd_stb;
  assign dm_raddr = DAW'(rd_bank) * DAW'(NUM_CH) + DAW'(src);

  // Stage C: load the shifter on the last bit of the current channel
  assign load_stb = (bit_idx == BIT_W'(SAMPLE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q  <= '0;
      tgt_q  <= '0;
      fill_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      if (cm_re) begin
        dst_q <= cm_raddr;
        tgt_q <= last_ch ? bank_add(bank_eff, 1) : bank_eff;
      end
      if (rd_stb) fill_q <= var_mode & ~var_en;
      if (load_stb) sh_q <= fill_q ? '1 : dm_rdata;
      else          sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
    end
  end

  assign ser_o = sh_q[SAMPLE_W-1];
endmodule

// File: rtl/tsi_chan_switch.sv
module tsi_chan_switch
  import tsi_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int VAR_GAP = 7,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fp_i,
  input  logic            ser_i,
  output logic            ser_o,
  input  logic            cm_we,
  input  logic [CH_W-1:0] cm_addr,
  input  logic [15:0]     cm_wdata,
  input  logic            ctl_we,
  input  logic [15:0]     ctl_wdata
);
  localparam int POS_W = $clog2(NUM_CH * SAMPLE_W);
  localparam int DEPTH = NUM_BANKS * NUM_CH;
  localparam int DAW   = $clog2(DEPTH);
  localparam int CMW   = CH_W + 1;

  logic [POS_W-1:0]    pos_eff, pos_q;
  bank_t               bank_eff, bank_q;
  logic                var_en_q;
  logic [SAMPLE_W-1:0] rx_q, rx_byte;
  logic [CH_W-1:0]     in_ch;
  logic [BIT_W-1:0]    in_bit;
  logic                dm_we, dm_re;
  logic [DAW-1:0]      dm_waddr, dm_raddr;
  logic [SAMPLE_W-1:0] dm_rdata;
  logic                cm_re;
  logic [CH_W-1:0]     cm_raddr;
  logic [CMW-1:0]      cm_word, cm_rdata;
  logic                rd_stb, load_stb, fill_q;
  logic [SAMPLE_W-1:0] sh_q;
  logic                unused_bits;

  tsi_frame_timer #(.NUM_CH(NUM_CH)) timer_i (
    .clk(clk), .rst(rst), .fp_i(fp_i),
    .pos_eff(pos_eff), .pos_q(pos_q),
    .bank_eff(bank_eff), .bank_q(bank_q)
  );

  // Global control: variable-delay enable
  always_ff @(posedge clk) begin
    if (rst)         var_en_q <= 1'b0;
    else if (ctl_we) var_en_q <= ctl_wdata[CTL_VAREN_BIT];
  end

  // Receive side: deserialise and store each sample into the frame's bank
  assign in_bit  = pos_eff[BIT_W-1:0];
  assign in_ch   = pos_eff[POS_W-1:BIT_W];
  assign rx_byte = {rx_q[SAMPLE_W-2:0], ser_i};
  assign dm_we   = (in_bit == BIT_W'(SAMPLE_W - 1));
  assign dm_waddr = DAW'(bank_eff) * DAW'(NUM_CH) + DAW'(in_ch);

  always_ff @(posedge clk) begin
    if (rst) rx_q <= '0;
    else     rx_q <= rx_byte;
  end

  tsi_sdp_ram #(.DW(SAMPLE_W), .DEPTH(DEPTH)) data_mem_i (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(rx_byte),
    .re(dm_re), .raddr(dm_raddr), .rdata(dm_rdata)
  );

  // Connection memory: {variable mode, source channel}
  assign cm_word = {cm_wdata[CM_VAR_BIT], cm_wdata[CH_W-1:0]};

  tsi_sdp_ram #(.DW(CMW), .DEPTH(NUM_CH)) conn_mem_i (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wdata(cm_word),
    .re(cm_re), .raddr(cm_raddr), .rdata(cm_rdata)
  );

  tsi_out_path #(.NUM_CH(NUM_CH), .VAR_GAP(VAR_GAP)) out_i (
    .clk(clk), .rst(rst), .pos_eff(pos_eff), .bank_eff(bank_eff),
    .var_en(var_en_q), .cm_rdata(cm_rdata), .dm_rdata(dm_rdata),
    .cm_re(cm_re), .cm_raddr(cm_raddr), .dm_re(dm_re), .dm_raddr(dm_raddr),
    .rd_stb(rd_stb), .load_stb(load_stb), .fill_q(fill_q), .sh_q(sh_q),
    .ser_o(ser_o)
  );

  assign unused_bits = ^{cm_wdata, ctl_wdata};
endmodule

// File: rtl/tsi_chan_switch_chk.sv
module tsi_chan_switch_chk
  import tsi_pkg::*;
#(
  parameter int POS_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                fp_i,
  input logic                ser_o,
  input logic [POS_W-1:0]    pos_q,
  input bank_t               bank_q,
  input logic                var_en_q,
  input logic                rd_stb,
  input logic                load_stb,
  input logic                fill_q,
  input logic [SAMPLE_W-1:0] sh_q
);
  // R1: leaving reset, output is low and variable enable is clear
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ser_o && !var_en_q));

  // R2: a frame pulse restarts the position count
  p_fp_origin_r2: assert property (@(posedge clk) disable iff (rst)
    fp_i |=> (pos_q == POS_W'(1)));

  // R3: each frame pulse rotates the write bank by one, modulo three
  p_bank_step_r3: assert property (@(posedge clk) disable iff (rst)
    fp_i |=> (bank_q == bank_add($past(bank_q), 1)));

  p_bank_range_r3: assert property (@(posedge clk) disable iff (rst)
    bank_q != 2'd3);

  // R7: all-ones fill is never chosen while variable enable is set
  p_no_fill_when_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && var_en_q) |=> !fill_q);

  // R7: a fill request loads all ones into the shifter
  p_fill_loads_ones_r7: assert property (@(posedge clk) disable iff (rst)
    (load_stb && fill_q) |=> (sh_q == '1));
endmodule

bind tsi_chan_switch tsi_chan_switch_chk #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rst(rst), .fp_i(fp_i), .ser_o(ser_o), .pos_q(pos_q),
  .bank_q(bank_q), .var_en_q(var_en_q), .rd_stb(rd_stb),
  .load_stb(load_stb), .fill_q(fill_q), .sh_q(sh_q)
);

// File: tb/tsi_chan_switch_tb_top.sv
module tsi_chan_switch_tb_top;
  localparam int NCH     = 32;
  localparam int CHW     = $clog2(NCH);
  localparam int FBITS   = NCH * 8;
  localparam int NFRAMES = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fp_i = 1'b0, ser_i = 1'b0, cm_we = 1'b0, ctl_we = 1'b0;
  logic [CHW-1:0] cm_addr = '0;
  logic [15:0] cm_wdata = '0, ctl_wdata = '0;
  logic ser_o;

  always #10 clk = ~clk;   // 50 MHz

  tsi_chan_switch #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst(rst), .fp_i(fp_i), .ser_i(ser_i), .ser_o(ser_o),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit tb_active = 1'b0;
  int tb_pos = 0;

  // Configuration as the bench believes it to be
  int cfg_src [NCH];
  bit cfg_var [NCH];
  bit cfg_en = 1'b0;

  // Scoreboard queues
  logic [7:0] exp_q [$];
  bit         chk_q [$];
  string      tag_q [$];

  function automatic logic [7:0] in_byte(int f, int c);
    logic [7:0] b;
    b = 8'((f * 53 + c * 11 + 3) & 255);
    if (b == 8'hFF) b = 8'h5A;
    return b;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  function automatic bit frame_checked(int f);
    return (f >= 2 && f <= 5) || (f >= 7 && f <= 9) || (f >= 11);
  endfunction

  // Driver side: expected bytes for a whole output frame
  task automatic push_frame(int f);
    for (int d = 0; d < NCH; d++) begin
      int s, rf;
      string tag;
      logic [7:0] e;
      s = cfg_src[d];
      if (!cfg_var[d]) begin
        rf = f - 2; tag = "R3";
      end else if (d >= s + 7) begin
        rf = f; tag = "R4";
      end else if (d + NCH >= s + 7) begin
        rf = f - 1; tag = "R5";
      end else begin
        rf = f - 2; tag = "R6";
      end
      if (cfg_var[d] && !cfg_en) begin
        e = 8'hFF; tag = "R7 R8";
      end else begin
        e = in_byte(rf < 0 ? 0 : rf, s);
      end
      if (d == 0) tag = {tag, " R2"};
      if (f <= 5) tag = {tag, " R8 R9"};
      exp_q.push_back(e);
      chk_q.push_back(frame_checked(f) && rf >= 0);
      tag_q.push_back($sformatf("%s frame %0d ch %0d", tag, f, d));
    end
  endtask

  function automatic void config_a(int d, output bit v, output int s);
    if (d == 0)           begin v = 1; s = 29; end          // R6 case
    else if (d == 1)      begin v = 1; s = 31; end          // R6 case
    else if (d == 20)     begin v = 1; s = 5;  end          // R4 case
    else if (d == NCH-1)  begin v = 1; s = 0;  end          // R4 case
    else if (d % 3 == 0)  begin v = 0; s = (d * 7 + 3) % NCH; end
    else                  begin v = 1; s = (d * 13 + 5) % NCH; end
  endfunction

  // Monitor: deserialise ser_o and compare against the queue
  initial begin
    logic [7:0] acc;
    acc = '0;
    forever begin
      @(negedge clk);
      #2;
      if (tb_active) begin
        acc = {acc[6:0], ser_o};
        if (tb_pos % 8 == 7) begin
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 scoreboard empty: actual %02h expected none", acc);
          end else begin
            logic [7:0] e;
            bit c;
            string t;
            e = exp_q.pop_front();
            c = chk_q.pop_front();
            t = tag_q.pop_front();
            if (c) check(t, acc, e, "output byte");
          end
        end
      end
    end
  end

  // Stimulus
  initial begin
    repeat (3) @(negedge clk);
    check("R1", {7'b0, ser_o}, 8'h00, "ser_o during reset");
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", {7'b0, ser_o}, 8'h00, "ser_o after reset");
    end

    // Program connections (junk in unused bits) and enable variable mode
    for (int d = 0; d < NCH; d++) begin
      bit v;
      int s;
      config_a(d, v, s);
      cfg_var[d] = v;
      cfg_src[d] = s;
      @(negedge clk);
      cm_we = 1'b1;
      cm_addr = CHW'(d);
      cm_wdata = 16'hA100 | (16'(v) << 14) | 16'(s);
    end
    @(negedge clk);
    cm_we = 1'b0;
    ctl_we = 1'b1;
    ctl_wdata = 16'h8011;
    cfg_en = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;

    for (int f = 0; f < NFRAMES; f++) begin
      for (int p = 0; p < FBITS; p++) begin
        logic [7:0] b;
        @(negedge clk);
        if (p == 0) push_frame(f);
        b = in_byte(f, p / 8);
        fp_i = (p == 0);
        ser_i = b[7 - (p % 8)];
        tb_pos = p;
        tb_active = 1'b1;
        ctl_we = 1'b0;
        cm_we = 1'b0;
        if (f == 6 && p == 8) begin
          ctl_we = 1'b1;
          ctl_wdata = 16'hFFEF;       // enable bit clear, others set
          cfg_en = 1'b0;
        end
        if (f == 10 && p >= 8 && p < 8 + NCH) begin
          int d;
          d = p - 8;
          cm_we = 1'b1;
          cm_addr = CHW'(d);
          cm_wdata = 16'h2000 | 16'(NCH - 1 - d);
          cfg_var[d] = 1'b0;
          cfg_src[d] = NCH - 1 - d;
        end
      end
    end
    @(negedge clk);
    fp_i = 1'b0;
    cm_we = 1'b0;
    ctl_we = 1'b0;
    tb_active = 1'b0;
    #5;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule